// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between a clock synthesizer's internal clock sources and its output pins. It turns a processor-side clock group (the CPU outputs and the graphics-port outputs) and a bus-side clock group (the PCI outputs) on and off. Gating follows two active-low stop requests and one enable bit per output. Gating never cuts a pulse short. A stopped output rests low. A restarted output always begins with a complete high phase.

Stop requests and enable bits are sampled on the rising edge of the free-running PCI clock. Each gate then moves its decision into its own clock's falling-edge domain. The CPU and graphics-port groups run asynchronously to the sampling clock, so they use a two-stage chain. The PCI group runs on the sampling clock itself, so it needs only one stage. Each output is the AND of its source clock and a gate flop that changes only while that clock is low. A free-running copy of the PCI clock ignores both stop requests and answers only to its own enable bit. A mode input can turn the stop-pin function off entirely, as when those pins are given over to clock outputs.

Top module: `clkstop_gate`

## Requirements
- R1: While rst_n is low, every gated output is held low. After release, outputs whose enable bit is 1 start toggling once the first clk_pci rising edge has passed through their gate.
- R2: cpu_stop_n_i and pci_stop_n_i are active low and are looked at only on clk_pci rising edges. A low pulse that starts and ends between two rising edges has no effect on any output.
- R3: A sampled low on cpu_stop_n_i stops every CPU output and every graphics-port output. The PCI outputs and the free-running output keep toggling.
- R4: A sampled low on pci_stop_n_i stops every PCI output. The CPU outputs, the graphics-port outputs and the free-running output keep toggling.
- R5: Bit i of each enable vector (cpu_en_i, agp_en_i, pci_en_i) controls output i of the same group, and free_en_i controls free_clk_o. Value 1 means run. An output runs only when its bit is 1 and its group has no sampled stop request. A bit cleared on the same sampling edge as a stop release keeps that output low.
- R6: When stop_pins_off_i is 1, both stop inputs are treated as deasserted whatever their level. When it is 0, they act as described in R3 and R4.
- R7: Every high pulse on a gated output lasts exactly one full high phase of its source clock. A stopped output is held low.
- R8: After a clk_pci rising edge samples a change, a CPU or graphics-port gate changes state at the second falling edge of its own clock that comes strictly after that sampling edge. A falling edge that coincides with the sampling edge does not count. A PCI or free-running gate changes state at the next clk_pci falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Ungated CPU clock source |
| clk_agp | input | 1 | Ungated graphics-port clock source |
| clk_pci | input | 1 | Free-running PCI clock; samples requests and sources the PCI group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pins_off_i | input | 1 | 1 = stop inputs ignored |
| cpu_stop_n_i | input | 1 | Active-low stop request for the CPU and graphics-port groups |
| pci_stop_n_i | input | 1 | Active-low stop request for the PCI group |
| cpu_en_i | input | N_CPU | Per-output run enables, CPU group |
| agp_en_i | input | N_AGP | Per-output run enables, graphics-port group |
| pci_en_i | input | N_PCI | Per-output run enables, PCI group |
| free_en_i | input | 1 | Run enable for the free-running PCI output |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| agp_clk_o | output | N_AGP | Gated graphics-port clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| free_clk_o | output | 1 | Free-running PCI clock output |

## Verification
The two functions that can meet on one sampling edge are the release of a stop request and the clearing of a register enable bit. Both feed the same sampled run decision, so an error in how they are combined would let the cleared output resume. The bench stops the CPU group, then in a single window between two clk_pci rising edges it raises cpu_stop_n_i and clears one CPU enable bit. It then checks, during the high phases that follow, that every other CPU output runs again and that the cleared one stays low. Pulse-width monitors run for the whole test, so any runt created at those gate changes is also reported.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Sampled stop decision per clock group
    typedef struct packed {
        logic cpu_grp;
        logic pci_grp;
    } grp_hold_t;

    // Width of the lag counter used by the gate checkers
    localparam int unsigned LAG_W = 4;

endpackage

// File: rtl/clkstop_hold_decode.sv
`timescale 1ns/1ps
module clkstop_hold_decode
    import clkstop_pkg::*;
(
    input  logic      pins_off_i,
    input  logic      cpu_stop_n_i,
    input  logic      pci_stop_n_i,
    output grp_hold_t hold_o
);

    grp_hold_t hold_d;

    always_comb begin
        hold_d         = '0;
        hold_d.cpu_grp = ~cpu_stop_n_i & ~pins_off_i;
        hold_d.pci_grp = ~pci_stop_n_i & ~pins_off_i;
    end

    assign hold_o = hold_d;

endmodule

// File: rtl/clkstop_gate_cell.sv
`timescale 1ns/1ps
module clkstop_gate_cell
    import clkstop_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_ref_i,
    input  logic clk_src_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic hold_i,
    output logic clk_o
);

    typedef struct packed {
        logic run;
    } ref_state_t;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } src_state_t;

    ref_state_t ref_d, ref_q;
    src_state_t src_d, src_q;
    logic       gate_open;

    // Sampling domain: rising edge of the free-running reference
    always_comb begin
        ref_d     = ref_q;
        ref_d.run = en_i & ~hold_i;
    end

    always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
        if (!rst_n_i) ref_q <= '0;
        else          ref_q <= ref_d;
    end

    // Gate domain: falling edge of the clock being gated
    always_comb begin
        src_d          = src_q;
        src_d.chain    = src_q.chain << 1;
        src_d.chain[0] = ref_q.run;
    end

    always_ff @(negedge clk_src_i or negedge rst_n_i) begin
        if (!rst_n_i) src_q <= '0;
        else          src_q <= src_d;
    end

    assign gate_open = src_q.chain[SYNC_STAGES-1];
    assign clk_o     = clk_src_i & gate_open;

    // Checker state: falling edges spent waiting on a stable request,
    // and the gate value seen at the start of each high phase.
    logic [LAG_W-1:0] lag_q;
    logic             run_seen_q;
    logic             high_gate_q;

    always_ff @(negedge clk_src_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            lag_q      <= '0;
            run_seen_q <= 1'b0;
        end else begin
            run_seen_q <= ref_q.run;
            if (gate_open == ref_q.run)      lag_q <= '0;
            else if (ref_q.run != run_seen_q) lag_q <= LAG_W'(1);
            else if (lag_q != '1)            lag_q <= lag_q + LAG_W'(1);
        end
    end

    always_ff @(posedge clk_src_i or negedge rst_n_i) begin
        if (!rst_n_i) high_gate_q <= 1'b0;
        else          high_gate_q <= gate_open;
    end

    // R8
    lag_bound_chk: assert property (@(negedge clk_src_i) disable iff (!rst_n_i)
        lag_q <= LAG_W'(SYNC_STAGES));

    // R7
    full_high_chk: assert property (@(negedge clk_src_i) disable iff (!rst_n_i)
        clk_o == high_gate_q);

    // R3
    hold_close_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        hold_i |=> !ref_q.run);

endmodule

// File: rtl/clkstop_gate_bank.sv
`timescale 1ns/1ps
module clkstop_gate_bank #(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_ref_i,
    input  logic             clk_src_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic             hold_i,
    output logic [WIDTH-1:0] clk_o
);

    localparam int unsigned LAST = WIDTH - 1;

    for (genvar g = 0; g <= LAST; g++) begin : g_cell
        clkstop_gate_cell #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_cell (
            .clk_ref_i(clk_ref_i),
            .clk_src_i(clk_src_i),
            .rst_n_i  (rst_n_i),
            .en_i     (en_i[g]),
            .hold_i   (hold_i),
            .clk_o    (clk_o[g])
        );
    end

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU    = 4,
    parameter int unsigned N_AGP    = 2,
    parameter int unsigned N_PCI    = 5,
    parameter int unsigned CPU_SYNC = 2,
    parameter int unsigned AGP_SYNC = 2,
    parameter int unsigned PCI_SYNC = 1
) (
    input  logic             clk_cpu,
    input  logic             clk_agp,
    input  logic             clk_pci,
    input  logic             rst_n,
    input  logic             stop_pins_off_i,
    input  logic             cpu_stop_n_i,
    input  logic             pci_stop_n_i,
    input  logic [N_CPU-1:0] cpu_en_i,
    input  logic [N_AGP-1:0] agp_en_i,
    input  logic [N_PCI-1:0] pci_en_i,
    input  logic             free_en_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_AGP-1:0] agp_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             free_clk_o
);

    localparam int unsigned FREE_SYNC = PCI_SYNC;

    grp_hold_t hold;
    logic      free_vec;

    clkstop_hold_decode u_decode (
        .pins_off_i  (stop_pins_off_i),
        .cpu_stop_n_i(cpu_stop_n_i),
        .pci_stop_n_i(pci_stop_n_i),
        .hold_o      (hold)
    );

    clkstop_gate_bank #(.WIDTH(N_CPU), .SYNC_STAGES(CPU_SYNC)) u_cpu_bank (
        .clk_ref_i(clk_pci),
        .clk_src_i(clk_cpu),
        .rst_n_i  (rst_n),
        .en_i     (cpu_en_i),
        .hold_i   (hold.cpu_grp),
        .clk_o    (cpu_clk_o)
    );

    clkstop_gate_bank #(.WIDTH(N_AGP), .SYNC_STAGES(AGP_SYNC)) u_agp_bank (
        .clk_ref_i(clk_pci),
        .clk_src_i(clk_agp),
        .rst_n_i  (rst_n),
        .en_i     (agp_en_i),
        .hold_i   (hold.cpu_grp),
        .clk_o    (agp_clk_o)
    );

    clkstop_gate_bank #(.WIDTH(N_PCI), .SYNC_STAGES(PCI_SYNC)) u_pci_bank (
        .clk_ref_i(clk_pci),
        .clk_src_i(clk_pci),
        .rst_n_i  (rst_n),
        .en_i     (pci_en_i),
        .hold_i   (hold.pci_grp),
        .clk_o    (pci_clk_o)
    );

    clkstop_gate_bank #(.WIDTH(1), .SYNC_STAGES(FREE_SYNC)) u_free_bank (
        .clk_ref_i(clk_pci),
        .clk_src_i(clk_pci),
        .rst_n_i  (rst_n),
        .en_i     (free_en_i),
        .hold_i   (1'b0),
        .clk_o    (free_vec)
    );

    assign free_clk_o = free_vec;

    // R6
    pins_off_chk: assert property (@(posedge clk_pci) disable iff (!rst_n)
        stop_pins_off_i |-> (hold == '0));

endmodule

// File: tb/clkstop_gate_test.sv
`timescale 1ns/1ps
module clkstop_gate_test;

    logic       clk_cpu, clk_agp, clk_pci, rst_n;
    logic       stop_pins_off_i, cpu_stop_n_i, pci_stop_n_i;
    logic [3:0] cpu_en_i;
    logic [1:0] agp_en_i;
    logic [4:0] pci_en_i;
    logic       free_en_i;
    logic [3:0] cpu_clk_o;
    logic [1:0] agp_clk_o;
    logic [4:0] pci_clk_o;
    logic       free_clk_o;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    int  phase = 0;

    clkstop_gate uut (
        .clk_cpu(clk_cpu), .clk_agp(clk_agp), .clk_pci(clk_pci), .rst_n(rst_n),
        .stop_pins_off_i(stop_pins_off_i), .cpu_stop_n_i(cpu_stop_n_i),
        .pci_stop_n_i(pci_stop_n_i), .cpu_en_i(cpu_en_i), .agp_en_i(agp_en_i),
        .pci_en_i(pci_en_i), .free_en_i(free_en_i), .cpu_clk_o(cpu_clk_o),
        .agp_clk_o(agp_clk_o), .pci_clk_o(pci_clk_o), .free_clk_o(free_clk_o)
    );

    // 200 MHz CPU clock; graphics-port clock at half and PCI clock at a quarter
    initial begin
        clk_cpu = 0; clk_agp = 0; clk_pci = 0;
        forever begin
            #2.5;
            phase++;
            clk_cpu = ~clk_cpu;
            if (phase % 2 == 0) clk_agp = ~clk_agp;
            if (phase % 4 == 0) clk_pci = ~clk_pci;
        end
    end

    // Pulse-width monitors (R7)
    realtime rise_cpu, rise_agp, rise_pci, rise_free;
    int n_cpu = 0, n_agp = 0, n_pci = 0, n_free = 0;
    int runt_cpu = 0, runt_agp = 0, runt_pci = 0, runt_free = 0;

    always @(posedge cpu_clk_o[0]) rise_cpu = $realtime;
    always @(negedge cpu_clk_o[0]) begin
        n_cpu++;
        if ($realtime - rise_cpu < 2.49 || $realtime - rise_cpu > 2.51) runt_cpu++;
    end
    always @(posedge agp_clk_o[0]) rise_agp = $realtime;
    always @(negedge agp_clk_o[0]) begin
        n_agp++;
        if ($realtime - rise_agp < 4.99 || $realtime - rise_agp > 5.01) runt_agp++;
    end
    always @(posedge pci_clk_o[0]) rise_pci = $realtime;
    always @(negedge pci_clk_o[0]) begin
        n_pci++;
        if ($realtime - rise_pci < 9.99 || $realtime - rise_pci > 10.01) runt_pci++;
    end
    always @(posedge free_clk_o) rise_free = $realtime;
    always @(negedge free_clk_o) begin
        n_free++;
        if ($realtime - rise_free < 9.99 || $realtime - rise_free > 10.01) runt_free++;
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Move to a quiet point between clk_pci rising edges
    task automatic to_mid();
        @(negedge clk_pci);
        #1.25;
    endtask

    // Sample every group during a high phase following the next clk_pci rise
    task automatic check_state(input string tag, input logic [3:0] e_cpu,
                               input logic [1:0] e_agp, input logic [4:0] e_pci,
                               input logic e_free);
        @(posedge clk_pci);
        #6.25;
        chk({tag, " pci"},  8'(pci_clk_o), 8'(e_pci));
        chk({tag, " free"}, 8'(free_clk_o), 8'(e_free));
        #2.5;
        chk({tag, " cpu"},  8'(cpu_clk_o), 8'(e_cpu));
        #7.5;
        chk({tag, " agp"},  8'(agp_clk_o), 8'(e_agp));
    endtask

    task automatic t_reset();
        #3.75;  chk("R1 cpu low in reset", 8'(cpu_clk_o), 8'h0);
        #5;     chk("R1 agp low in reset", 8'(agp_clk_o), 8'h0);
        #6.25;  chk("R1 pci low in reset", 8'(pci_clk_o), 8'h0);
                chk("R1 free low in reset", 8'(free_clk_o), 8'h0);
        #26.25; rst_n = 1;
        @(posedge clk_pci);
        check_state("R1 running after reset", 4'hF, 2'h3, 5'h1F, 1'b1);
    endtask

    task automatic t_cpu_stop();
        realtime t0;
        to_mid();
        cpu_stop_n_i = 0;
        @(posedge clk_pci);
        t0 = $realtime;
        #8.75;  chk("R8 cpu still open 2nd fall", 8'(cpu_clk_o), 8'hF);
        #5;     chk("R8 cpu closed after 2nd fall", 8'(cpu_clk_o), 8'h0);
        #2.5;   chk("R8 agp still open", 8'(agp_clk_o), 8'h3);
        #10;    chk("R8 agp closed", 8'(agp_clk_o), 8'h0);
                chk("R3 pci unaffected", 8'(pci_clk_o), 8'h1F);
                chk("R3 free unaffected", 8'(free_clk_o), 8'h1);
        check_state("R3 cpu group stopped", 4'h0, 2'h0, 5'h1F, 1'b1);
        to_mid();
        cpu_stop_n_i = 1;
        @(posedge clk_pci);
        #8.75;  chk("R8 cpu still closed", 8'(cpu_clk_o), 8'h0);
        #5;     chk("R8 cpu reopened full pulse", 8'(cpu_clk_o), 8'hF);
        #2.5;   chk("R8 agp still closed", 8'(agp_clk_o), 8'h0);
        #10;    chk("R8 agp reopened", 8'(agp_clk_o), 8'h3);
        if (t0 < 0) bad++;
    endtask

    task automatic t_pci_stop();
        to_mid();
        pci_stop_n_i = 0;
        @(posedge clk_pci);
        #6.25;  chk("R8 pci open before fall", 8'(pci_clk_o), 8'h1F);
        #20;    chk("R8 pci closed", 8'(pci_clk_o), 8'h0);
                chk("R4 free unaffected", 8'(free_clk_o), 8'h1);
        #2.5;   chk("R4 cpu unaffected", 8'(cpu_clk_o), 8'hF);
        check_state("R4 pci group stopped", 4'hF, 2'h3, 5'h00, 1'b1);
        to_mid();
        pci_stop_n_i = 1;
        @(posedge clk_pci);
        #6.25;  chk("R8 pci still closed", 8'(pci_clk_o), 8'h0);
        #20;    chk("R8 pci reopened", 8'(pci_clk_o), 8'h1F);
    endtask

    task automatic t_enables();
        to_mid();
        cpu_en_i = 4'b1101; agp_en_i = 2'b01; pci_en_i = 5'b10111; free_en_i = 0;
        @(posedge clk_pci);
        check_state("R5 partial enables", 4'hD, 2'h1, 5'h17, 1'b0);
        to_mid();
        cpu_en_i = 4'hF; agp_en_i = 2'h3; pci_en_i = 5'h1F; free_en_i = 1;
        cpu_stop_n_i = 0;
        @(posedge clk_pci);
        check_state("R5 stop with enables", 4'h0, 2'h0, 5'h1F, 1'b1);
        // stop release and enable clear on one sampling edge
        to_mid();
        cpu_stop_n_i = 1;
        cpu_en_i = 4'b1011;
        @(posedge clk_pci);
        check_state("R5 release with cleared bit", 4'hB, 2'h3, 5'h1F, 1'b1);
        to_mid();
        cpu_en_i = 4'hF;
        @(posedge clk_pci);
        check_state("R5 enables restored", 4'hF, 2'h3, 5'h1F, 1'b1);
    endtask

    task automatic t_pins_off();
        to_mid();
        stop_pins_off_i = 1; cpu_stop_n_i = 0; pci_stop_n_i = 0;
        @(posedge clk_pci);
        check_state("R6 stops ignored", 4'hF, 2'h3, 5'h1F, 1'b1);
        to_mid();
        stop_pins_off_i = 0;
        @(posedge clk_pci);
        check_state("R6 stops honoured", 4'h0, 2'h0, 5'h00, 1'b1);
        to_mid();
        cpu_stop_n_i = 1; pci_stop_n_i = 1;
        @(posedge clk_pci);
        check_state("R6 released", 4'hF, 2'h3, 5'h1F, 1'b1);
    endtask

    task automatic t_short_pulse();
        @(posedge clk_pci);
        #1.25;  cpu_stop_n_i = 0; pci_stop_n_i = 0;
        #15;    cpu_stop_n_i = 1; pci_stop_n_i = 1;
        check_state("R2 unsampled pulse ignored", 4'hF, 2'h3, 5'h1F, 1'b1);
        check_state("R2 still running", 4'hF, 2'h3, 5'h1F, 1'b1);
    endtask

    task automatic t_widths();
        chk("R7 cpu runt pulses", 8'(runt_cpu), 8'h0);
        chk("R7 agp runt pulses", 8'(runt_agp), 8'h0);
        chk("R7 pci runt pulses", 8'(runt_pci), 8'h0);
        chk("R7 free runt pulses", 8'(runt_free), 8'h0);
        chk("R7 cpu pulses seen", 8'(n_cpu > 10), 8'h1);
        chk("R7 pci pulses seen", 8'(n_pci > 10), 8'h1);
    endtask

    initial begin
        rst_n = 0; stop_pins_off_i = 0; cpu_stop_n_i = 1; pci_stop_n_i = 1;
        cpu_en_i = 4'hF; agp_en_i = 2'h3; pci_en_i = 5'h1F; free_en_i = 1;
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_enables();
        t_pins_off();
        t_short_pulse();
        t_widths();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule